// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a bit-level I2C master for reading and writing registers inside a sensor-style slave. A caller hands it one command: a 7-bit slave address, a 7-bit register number, an auto-increment flag, a direction and a byte count. The block then runs the whole bus transaction on its own. It raises START, sends the slave address and the register byte, and moves the data bytes. For a read it inserts a repeated START. It ends with STOP. Write bytes are pulled from the caller one at a time, and read bytes come back with a one-cycle valid pulse.

Both bus lines are open-drain. The block never drives a high level: each line has an output enable that pulls it low when set, and the real line level is read back on a separate input. The SCL rate comes from the system clock through a parameterised quarter-period divider. Each bit takes four quarters. SDA moves in the middle of the low half and is sampled in the middle of the high half. A slave that holds SCL low stretches the current bit. If the slave leaves an acknowledge slot high, the transfer is cut short with STOP and an error flag is raised.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, and whenever busy is low, both line enables (scl_oe, sda_oe) are 0 and busy, rd_valid, wr_take and nack_err are 0.
- R2: A command is taken only when cmd_valid is high and busy is low. busy then stays high until the STOP has completed. A cmd_valid raised while busy is ignored and starts no second transaction.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Inside every data or acknowledge bit, SDA changes only while SCL is low.
- R4: The first byte after START is {slave address, R/W}, with R/W = 0 for write and 1 for read. The second byte is {auto-increment flag, register number}, the flag in bit 7. Every byte goes out MSB first.
- R5: A write sends the address byte with R/W = 0, then the register byte, then cmd_cnt+1 data bytes, then STOP. Each data byte is the wr_data value present when it is loaded, and each load is followed by a one-cycle wr_take pulse.
- R6: A read sends the address byte with R/W = 0 and the register byte, then a repeated START, then the address byte with R/W = 1. It then receives cmd_cnt+1 bytes, each presented on rd_data with a one-cycle rd_valid pulse, and ends with STOP.
- R7: During a read the master acknowledges (SDA low) every received byte except the last, which it leaves unacknowledged (SDA released) before STOP.
- R8: If a slave leaves SDA high in any acknowledge slot of a byte the master sent, the master issues STOP at once and sets nack_err. nack_err stays set until the next command is taken.
- R9: With no stretching, every SCL high phase and every SCL low phase lasts exactly 2*QTR_DIV clock cycles.
- R10: While SCL is released by the master but reads low, the bit timing is frozen. After the slave lets SCL go, the high phase still lasts the full 2*QTR_DIV cycles and the transfer completes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_rd | input | 1 | 1 = register read, 0 = register write |
| cmd_dev | input | 7 | Slave address |
| cmd_reg | input | 7 | Register number inside the slave |
| cmd_ainc | input | 1 | Auto-increment flag sent in bit 7 of the register byte |
| cmd_cnt | input | LEN_W | Number of data bytes minus one |
| wr_data | input | 8 | Write byte, sampled when the block loads the next byte |
| wr_take | output | 1 | One-cycle pulse after wr_data has been taken |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data holds a new byte |
| busy | output | 1 | Transaction in progress |
| nack_err | output | 1 | Set when a slave did not acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_i | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sensed SDA level |

## Verification
The bench builds the block with QTR_DIV = 4 and LEN_W = 4. The short quarter keeps each byte to under 150 cycles, so reads with repeated START, multi-byte auto-increment bursts and both NACK paths fit easily in one run. A slave stretch of 37 cycles spans several whole quarters, so it freezes the divider at the start of a high phase, which is the case where a shortened high pulse would show. The 4-bit count lets a single command carry up to sixteen bytes, so the bench can exercise both the first-byte and the last-byte acknowledge handling.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int DEV_W     = 7;
  localparam int REG_W     = 7;
  localparam int BYTE_W    = 8;
  localparam int SLOT_BITS = BYTE_W + 1;  // data bits plus acknowledge slot

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_RX,
    ST_RSTART,
    ST_STOP
  } mst_state_e;

  typedef enum logic [1:0] {
    BY_ADDR_W,
    BY_SUB,
    BY_WDATA,
    BY_ADDR_R
  } byte_kind_e;
endpackage

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
  parameter int QTR_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       hold,
  output logic       tick,
  output logic [1:0] qtr
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    qtr_q, qtr_d;

  assign tick = run && !hold && (cnt_q == LAST);
  assign qtr  = qtr_q;

  always_comb begin
    cnt_d = cnt_q;
    qtr_d = qtr_q;
    if (!run) begin
      cnt_d = '0;
      qtr_d = '0;
    end else if (!hold) begin
      if (tick) begin
        cnt_d = '0;
        qtr_d = qtr_q + 2'd1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      qtr_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      qtr_q <= qtr_d;
    end
  end
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] val
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = load_val;
    else if (shift) sh_d = {sh_q[W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign val = sh_q;
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
  import i2c_reg_pkg::*;
#(
  parameter int QTR_DIV = 8,
  parameter int LEN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic              cmd_ainc,
  input  logic [LEN_W-1:0]  cmd_cnt,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_take,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              nack_err,
  output logic              scl_oe,
  input  logic              scl_i,
  output logic              sda_oe,
  input  logic              sda_i
);
  localparam int IDX_W = $clog2(SLOT_BITS + 1);
  localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(SLOT_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(SLOT_BITS - 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  mst_state_e        state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  rem_q, rem_d, cnt_q;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  reg_q;
  logic              ainc_q, rd_q, latch;
  logic              ack_q, ack_d, err_q, err_d;
  logic              take_q, take_d, rdv_q, rdv_d;
  logic [BYTE_W-1:0] rd_data_q, sh_val, sh_out;
  logic              sh_load, sh_shift;
  logic              sda_q, sda_d, sda_keep, sda_want;
  logic              tick, hold, sym_end, sample_tick;
  logic [1:0]        qtr;

  assign busy        = (state_q != ST_IDLE);
  assign scl_oe      = busy && !(qtr[1] || state_q == ST_START);
  assign hold        = busy && !scl_oe && !scl_i;
  assign sym_end     = tick && (qtr == 2'd3);
  assign sample_tick = tick && (qtr == 2'd2);
  assign sh_shift    = sample_tick && (state_q == ST_TX || state_q == ST_RX) && (idx_q != ACK_IDX);

  i2c_qtr_timer #(.QTR_DIV(QTR_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .run(busy), .hold(hold), .tick(tick), .qtr(qtr)
  );

  i2c_byte_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .shift_in(sda_i), .val(sh_out)
  );

  // transaction sequencing
  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    err_d   = err_q;
    latch   = 1'b0;
    sh_load = 1'b0;
    sh_val  = wr_data;
    take_d  = 1'b0;
    rdv_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        state_d = ST_START;
        latch   = 1'b1;
        err_d   = 1'b0;
      end
      ST_START, ST_RSTART: if (sym_end) begin
        state_d = ST_TX;
        kind_d  = (state_q == ST_START) ? BY_ADDR_W : BY_ADDR_R;
        idx_d   = '0;
        sh_load = 1'b1;
        sh_val  = {dev_q, (state_q == ST_RSTART)};
      end
      ST_TX: if (sym_end) begin
        if (idx_q != ACK_IDX) begin
          idx_d = idx_q + 1'b1;
        end else if (!ack_q) begin
          state_d = ST_STOP;
          err_d   = 1'b1;
        end else begin
          idx_d = '0;
          unique case (kind_q)
            BY_ADDR_W: begin
              kind_d  = BY_SUB;
              sh_load = 1'b1;
              sh_val  = {ainc_q, reg_q};
            end
            BY_SUB: begin
              if (rd_q) begin
                state_d = ST_RSTART;
              end else begin
                kind_d  = BY_WDATA;
                rem_d   = cnt_q;
                sh_load = 1'b1;
                take_d  = 1'b1;
              end
            end
            BY_WDATA: begin
              if (rem_q == '0) begin
                state_d = ST_STOP;
              end else begin
                rem_d   = rem_q - 1'b1;
                sh_load = 1'b1;
                take_d  = 1'b1;
              end
            end
            BY_ADDR_R: begin
              state_d = ST_RX;
              rem_d   = cnt_q;
            end
          endcase
        end
      end
      ST_RX: if (sym_end) begin
        if (idx_q == LAST_BIT) rdv_d = 1'b1;
        if (idx_q != ACK_IDX) begin
          idx_d = idx_q + 1'b1;
        end else if (rem_q == '0) begin
          state_d = ST_STOP;
        end else begin
          rem_d = rem_q - 1'b1;
          idx_d = '0;
        end
      end
      ST_STOP: if (sym_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // SDA schedule per quarter; keep = hold the previous level
  always_comb begin
    sda_keep = 1'b1;
    sda_want = 1'b0;
    unique case (state_q)
      ST_IDLE:   sda_keep = 1'b0;
      ST_START:  begin sda_keep = 1'b0;          sda_want = (qtr == 2'd3); end
      ST_RSTART: begin sda_keep = (qtr == 2'd0); sda_want = (qtr == 2'd3); end
      ST_STOP:   begin sda_keep = (qtr == 2'd0); sda_want = (qtr != 2'd3); end
      ST_TX:     begin sda_keep = (qtr != 2'd1); sda_want = (idx_q != ACK_IDX) && !sh_out[BYTE_W-1]; end
      ST_RX:     begin sda_keep = (qtr != 2'd1); sda_want = (idx_q == ACK_IDX) && (rem_q != '0); end
      default:   sda_keep = 1'b0;
    endcase
    sda_d = sda_keep ? sda_q : sda_want;
    ack_d = ack_q;
    if (sample_tick && state_q == ST_TX && idx_q == ACK_IDX) ack_d = !sda_i;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q   <= ST_IDLE;
      kind_q    <= BY_ADDR_W;
      idx_q     <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      dev_q     <= '0;
      reg_q     <= '0;
      ainc_q    <= 1'b0;
      rd_q      <= 1'b0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
      take_q    <= 1'b0;
      rdv_q     <= 1'b0;
      rd_data_q <= '0;
      sda_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      take_q  <= take_d;
      rdv_q   <= rdv_d;
      sda_q   <= sda_d;
      if (rdv_d) rd_data_q <= sh_out;
      if (latch) begin
        cnt_q  <= cmd_cnt;
        dev_q  <= cmd_dev;
        reg_q  <= cmd_reg;
        ainc_q <= cmd_ainc;
        rd_q   <= cmd_rd;
      end
    end
  end

  assign sda_oe   = sda_q;
  assign wr_take  = take_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rd_data_q;
  assign nack_err = err_q;
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk
  import i2c_reg_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             scl_i,
  input logic             nack_err,
  input logic             rd_valid,
  input logic             wr_take,
  input mst_state_e       state_q,
  input logic [1:0]       qtr,
  input logic [DEV_W-1:0] dev_q,
  input logic [LEN_W-1:0] cnt_q,
  input logic             rd_q
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe && !rd_valid && !wr_take)); // R1

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dev_q) && $stable(cnt_q) && $stable(rd_q))); // R2

  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (state_q == ST_TX || state_q == ST_RX) && !scl_oe && $past(!scl_oe))
      |-> $stable(sda_oe)); // R3

  AST_TAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !rd_q); // R5

  AST_RDV_FROM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(state_q) == ST_RX)); // R6

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6

  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (state_q == ST_STOP)); // R8

  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_i) |=> ($stable(qtr) && $stable(state_q))); // R10
endmodule

bind i2c_reg_master i2c_reg_master_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .scl_i(scl_i), .nack_err(nack_err), .rd_valid(rd_valid), .wr_take(wr_take),
  .state_q(state_q), .qtr(qtr), .dev_q(dev_q), .cnt_q(cnt_q), .rd_q(rd_q)
);

// File: tb/i2c_reg_master_bench.sv
module i2c_reg_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV       = 4;
  localparam int LW         = 4;
  localparam logic [6:0] SLV = 7'h35;
  localparam int STRETCH_CYC = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0, cmd_ainc = 1'b0;
  logic [6:0] cmd_dev = '0, cmd_reg = '0;
  logic [LW-1:0] cmd_cnt = '0;
  logic [7:0] wr_data, rd_data;
  logic wr_take, rd_valid, busy, nack_err, scl_oe, sda_oe;
  logic stretch = 1'b0, slv_low = 1'b0;
  wire  scl_line = !scl_oe && !stretch;
  wire  sda_line = !sda_oe && !slv_low;

  int vectors = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  i2c_reg_master #(.QTR_DIV(QDIV), .LEN_W(LW)) u_i2c_reg_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_ainc(cmd_ainc), .cmd_cnt(cmd_cnt),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .nack_err(nack_err), .scl_oe(scl_oe), .scl_i(scl_line),
    .sda_oe(sda_oe), .sda_i(sda_line)
  );

  // caller side
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  int wr_idx = 0, rd_idx = 0;
  assign wr_data = wbuf[wr_idx[3:0]];
  always @(negedge clk) begin
    if (wr_take) wr_idx++;
    if (rd_valid) begin rbuf[rd_idx[3:0]] = rd_data; rd_idx++; end
  end

  // SCL phase length monitor
  int hi_run = 0, lo_run = 0, min_hi = 9999, min_lo = 9999, max_lo = 0;
  always @(negedge clk) begin
    if (scl_line) begin
      if (lo_run > 0 && busy) begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
      end
      lo_run = 0; hi_run++;
    end else begin
      if (hi_run > 0 && busy && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0; lo_run++;
    end
  end

  // slave model
  logic [7:0] mem [0:127];
  int starts = 0, stops = 0, mack_cnt = 0, mnack_cnt = 0;
  logic [7:0] last_addr = '0, s_sh = '0, s_txb = '0;
  logic [6:0] s_ptr = '0;
  logic s_active = 0, s_in_ack = 0, s_ainc = 0, s_mack = 0, s_first = 0, nack_data = 0;
  logic stretch_en = 0;
  int s_bit = 0, s_phase = 0;

  always @(negedge sda_line) if (scl_line) begin
    starts++; s_active = 1; s_phase = 0; s_bit = 0; s_in_ack = 0; slv_low = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stops++; s_active = 0; slv_low = 0;
  end
  always @(posedge scl_line) if (s_active) begin
    if (s_in_ack) begin
      if (s_phase == 3 && !s_first) begin
        s_mack = !sda_line;
        if (s_mack) mack_cnt++; else mnack_cnt++;
      end
    end else begin
      s_sh = {s_sh[6:0], sda_line}; s_bit++;
    end
  end
  always @(negedge scl_line) if (s_active) begin
    if (s_in_ack) begin
      s_in_ack = 0; s_bit = 0;
      if (s_phase == 3 && (s_first || s_mack)) begin
        if (!s_first && s_ainc) s_ptr++;
        s_first = 0; s_txb = mem[s_ptr]; slv_low = !s_txb[7];
      end else begin
        slv_low = 0;
        if (s_phase == 3) s_active = 0;
      end
    end else if (s_bit == 8) begin
      s_in_ack = 1;
      case (s_phase)
        0: begin
          last_addr = s_sh;
          if (s_sh[7:1] == SLV) begin
            s_phase = s_sh[0] ? 3 : 1; s_first = s_sh[0]; slv_low = 1;
          end else begin
            slv_low = 0; s_active = 0; s_in_ack = 0;
          end
        end
        1: begin s_ptr = s_sh[6:0]; s_ainc = s_sh[7]; s_phase = 2; slv_low = 1; end
        2: begin mem[s_ptr] = s_sh; if (s_ainc) s_ptr++; slv_low = !nack_data; end
        default: slv_low = 0;
      endcase
    end else if (s_phase == 3) begin
      slv_low = !s_txb[7 - s_bit];
    end
  end
  always @(negedge scl_line) if (stretch_en) begin
    stretch_en = 0; stretch = 1;
    #(STRETCH_CYC*CLK_PERIOD + 3);
    stretch = 0;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic rd, input logic [6:0] dev, input logic [6:0] rg,
                         input logic ainc, input logic [LW-1:0] cnt);
    @(negedge clk);
    wr_idx = 0; rd_idx = 0; min_hi = 9999; min_lo = 9999; max_lo = 0;
    cmd_rd = rd; cmd_dev = dev; cmd_reg = rg; cmd_ainc = ainc; cmd_cnt = cnt; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "busy", busy, 0);
    check("R1", "scl_oe", scl_oe, 0);
    check("R1", "sda_oe", sda_oe, 0);
    check("R1", "nack_err", nack_err, 0);
    check("R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic t_write_burst;
    int s0 = starts, p0 = stops;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    run_cmd(0, SLV, 7'h10, 1, 2);
    check("R5", "mem10", mem[7'h10], 8'hA1);
    check("R5", "mem11", mem[7'h11], 8'hB2);
    check("R5", "mem12", mem[7'h12], 8'hC3);
    check("R5", "takes", wr_idx, 3);
    check("R4", "addr byte", last_addr, 8'h6A);
    check("R3", "starts", starts - s0, 1);
    check("R3", "stops", stops - p0, 1);
    check("R9", "min high", min_hi, 2*QDIV);
    check("R9", "min low", min_lo, 2*QDIV);
    check("R8", "no err", nack_err, 0);
    check("R2", "busy after", busy, 0);
  endtask

  task automatic t_write_noinc;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    run_cmd(0, SLV, 7'h20, 0, 1);
    check("R4", "noinc reg", mem[7'h20], 8'h22);
    check("R4", "noinc next", mem[7'h21], 8'h00);
  endtask

  task automatic t_read_burst;
    int s0 = starts, p0 = stops, a0 = mack_cnt, n0 = mnack_cnt;
    run_cmd(1, SLV, 7'h10, 1, 2);
    check("R6", "count", rd_idx, 3);
    check("R6", "rd0", rbuf[0], 8'hA1);
    check("R6", "rd1", rbuf[1], 8'hB2);
    check("R6", "rd2", rbuf[2], 8'hC3);
    check("R6", "starts", starts - s0, 2);
    check("R6", "stops", stops - p0, 1);
    check("R4", "read addr byte", last_addr, 8'h6B);
    check("R7", "acks", mack_cnt - a0, 2);
    check("R7", "nacks", mnack_cnt - n0, 1);
  endtask

  task automatic t_read_single;
    int a0 = mack_cnt, n0 = mnack_cnt;
    run_cmd(1, SLV, 7'h11, 0, 0);
    check("R6", "single count", rd_idx, 1);
    check("R6", "single data", rbuf[0], 8'hB2);
    check("R7", "single acks", mack_cnt - a0, 0);
    check("R7", "single nack", mnack_cnt - n0, 1);
  endtask

  task automatic t_busy_ignore;
    int s0 = starts;
    wbuf[0] = 8'h5A;
    @(negedge clk);
    wr_idx = 0;
    cmd_rd = 0; cmd_dev = SLV; cmd_reg = 7'h30; cmd_ainc = 0; cmd_cnt = 0; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    repeat (20) @(negedge clk);
    cmd_reg = 7'h40; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    repeat (50) @(negedge clk);
    check("R2", "kept target", mem[7'h30], 8'h5A);
    check("R2", "ignored target", mem[7'h40], 8'h00);
    check("R2", "one start", starts - s0, 1);
    check("R2", "idle", busy, 0);
  endtask

  task automatic t_bad_addr;
    int s0 = starts, p0 = stops;
    wbuf[0] = 8'h77;
    run_cmd(0, 7'h22, 7'h50, 0, 0);
    check("R8", "err", nack_err, 1);
    check("R8", "stop", stops - p0, 1);
    check("R8", "start", starts - s0, 1);
    check("R8", "no take", wr_idx, 0);
    check("R8", "mem50", mem[7'h50], 8'h00);
  endtask

  task automatic t_nack_data;
    nack_data = 1;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    run_cmd(0, SLV, 7'h60, 1, 2);
    nack_data = 0;
    check("R8", "first kept", mem[7'h60], 8'h01);
    check("R8", "second absent", mem[7'h61], 8'h00);
    check("R8", "one take", wr_idx, 1);
    check("R8", "err data", nack_err, 1);
  endtask

  task automatic t_err_clear;
    wbuf[0] = 8'h9C;
    run_cmd(0, SLV, 7'h70, 0, 0);
    check("R8", "cleared", nack_err, 0);
    check("R5", "mem70", mem[7'h70], 8'h9C);
  endtask

  task automatic t_stretch;
    stretch_en = 1;
    run_cmd(1, SLV, 7'h10, 1, 1);
    check("R10", "count", rd_idx, 2);
    check("R10", "rd0", rbuf[0], 8'hA1);
    check("R10", "rd1", rbuf[1], 8'hB2);
    check("R10", "full high", min_hi, 2*QDIV);
    check("R10", "long low seen", int'(max_lo >= STRETCH_CYC), 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    for (int i = 0; i < 16; i++) begin wbuf[i] = 8'h00; rbuf[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write_burst;
    t_write_noinc;
    t_read_burst;
    t_read_single;
    t_busy_ignore;
    t_bad_addr;
    t_nack_data;
    t_err_clear;
    t_stretch;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule